// File: doc/BRIEF.md
# Parallel PRBS Word Generator

This block produces a pseudo-random binary test stream for exercising high-speed serial lanes. Every enabled clock it delivers a 32-bit word to a downstream serializer, so it computes 32 serial shift-register steps in one cycle. Three maximal-length polynomials are available: PRBS7, PRBS23 and PRBS31. An inversion control picks the inverted or the plain form of the stream. The plain form is the default, because the matching lane checker only accepts the plain form.

Serial convention: stage k of an N-stage register is `s[k]`. One serial step computes `fb = s[T] ^ s[N]`, where T is the polynomial's inner tap. It moves every stage up by one and loads `fb` into stage 1. The emitted bit is `fb`. Bit 0 of a word is the oldest bit in serial order, which is the first bit on the wire. The register is seeded with all ones, so it cannot get stuck at zero.

Top module: `prbs_word_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `valid_o` and `data_o` become 0. The register is loaded with all ones and the current pattern selection is captured.
- R2: Each word holds 32 consecutive serial bits, with bit 0 the oldest. From the all-ones seed, the first PRBS7 word has bits [6:0] equal to 7'b1000000.
- R3: `sel_i` = 2'b00 selects PRBS7 (x^7+x^6+1, tap 6 and 7). Its bit stream repeats every 127 bits.
- R4: `sel_i` = 2'b01 selects PRBS23 (x^23+x^18+1, tap 18 and 23).
- R5: `sel_i` = 2'b10 selects PRBS31 (x^31+x^28+1, tap 28 and 31), with a period of 2^31-1 bits.
- R6: The first word after reset, or after a reseed, is the one computed from an all-ones register.
- R7: Successive valid words continue the serial sequence with no bits skipped or repeated.
- R8: `inv_i` = 1 inverts every bit of the word produced at that edge; `inv_i` = 0 passes the plain stream. Toggling `inv_i` does not disturb the sequence position.
- R9: A clock edge with `en_i` low produces `valid_o` = 0, keeps `data_o`, and freezes the register. The next enabled word continues where the stream stopped.
- R10: An edge at which the effective pattern differs from the stored one produces no word (`valid_o` = 0). It reseeds the register to all ones, and the next enabled edge emits the new pattern's first word.
- R11: `sel_i` = 2'b11 behaves as PRBS31. Switching between 2'b10 and 2'b11 is not a pattern change and causes no reseed.
- R12: A valid word is never all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Advance the stream and emit a word |
| sel_i | input | 2 | Pattern: 00 PRBS7, 01 PRBS23, 10/11 PRBS31 |
| inv_i | input | 1 | 1 = emit inverted stream |
| data_o | output | 32 | Output word, bit 0 transmitted first |
| valid_o | output | 1 | Word on `data_o` is new this cycle |

## Verification
The hardest state to reach from the ports is a long-sequence property such as the PRBS7 period or the exact point where a stream resumes. That position is internal, so it shows only through the bit stream. The bench drives 127 consecutive PRBS7 words and compares every bit with the bit 127 positions earlier. It also interleaves idle cycles, inversion toggles and pattern switches in the middle of a stream. After each of these, the next word must match an independent serial model that was advanced only on enabled edges.

// File: rtl/prbs_pkg.sv
// Package: shared constants and helpers for the parallel PRBS generator.
// Assumes at most three polynomials, indexed 0..2; the select code 3 aliases index 2.
package prbs_pkg;

    localparam int WORD_W  = 32;
    localparam int NUM_PAT = 3;
    localparam int REG_W   = 31;

    typedef enum logic [1:0] {
        PAT_P7      = 2'b00,
        PAT_P23     = 2'b01,
        PAT_P31     = 2'b10,
        PAT_P31_ALT = 2'b11
    } pat_sel_e;

    // Register length of polynomial index idx.
    function automatic int pat_len(input int idx);
        case (idx)
            0:       return 7;
            1:       return 23;
            default: return 31;
        endcase
    endfunction

    // Inner feedback tap of polynomial index idx.
    function automatic int pat_tap(input int idx);
        case (idx)
            0:       return 6;
            1:       return 18;
            default: return 28;
        endcase
    endfunction

    // Map a select code onto a polynomial index.
    function automatic logic [1:0] pat_index(input logic [1:0] sel);
        return (sel == PAT_P31_ALT) ? 2'(PAT_P31) : sel;
    endfunction

endpackage

// File: rtl/prbs_leap.sv
// Module: prbs_leap
// Advances an N-stage Fibonacci LFSR by W serial steps in one combinational pass.
// Each step XORs stages TAP and N, shifts the register up and loads the result into stage 1.
// That result is also the emitted bit. Word bit 0 is the first step.
// Assumes 1 <= TAP < N.
module prbs_leap #(
    parameter int N   = 31,
    parameter int TAP = 28,
    parameter int W   = 32
) (
    input  logic [N-1:0] state_i,
    output logic [N-1:0] state_o,
    output logic [W-1:0] word_o
);

    // Unrolled serial stepping: W iterations of shift-and-feedback.
    always_comb begin
        logic [N-1:0] s;
        logic         fb;
        s      = state_i;
        word_o = '0;
        for (int i = 0; i < W; i++) begin
            fb        = s[TAP-1] ^ s[N-1];
            word_o[i] = fb;
            s         = {s[N-2:0], fb};
        end
        state_o = s;
    end

endmodule

// File: rtl/prbs_ctrl.sv
// Module: prbs_ctrl
// Decides, per clock, whether the generator advances, holds or reseeds.
// It keeps the effective pattern index in use. A change of effective pattern forces one reseed cycle.
// Assumes a synchronous active-low reset that captures the current selection.
module prbs_ctrl
    import prbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] sel_i,
    output logic [1:0] mode_o,
    output logic       adv_o,
    output logic       seed_o
);

    logic [1:0] mode_q;
    logic [1:0] want;

    // Effective pattern requested this cycle.
    always_comb want = pat_index(sel_i);

    // Action decode: reseed wins over advance.
    always_comb begin
        seed_o = (want != mode_q);
        adv_o  = en_i && !seed_o;
    end

    // Track the pattern the register currently holds.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= want;
        else        mode_q <= want;
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/prbs_outreg.sv
// Module: prbs_outreg
// Output stage: registers the word with optional inversion and drives the valid flag.
// Data holds its last value whenever no word is produced.
module prbs_outreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         inv_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] data_o,
    output logic         valid_o
);

    // Capture a new word on load, otherwise keep data and drop valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= load_i;
            if (load_i) data_o <= word_i ^ {W{inv_i}};
        end
    end

endmodule

// File: rtl/prbs_word_gen.sv
// Module: prbs_word_gen (top)
// 32-bit-per-cycle PRBS generator with PRBS7, PRBS23 and PRBS31 patterns and an inversion control.
// One shared 31-bit state register holds the active pattern in its low bits.
// One unrolled stepper per polynomial runs in parallel, and the stored pattern index picks the result.
// Assumes the selection is quasi-static. Any effective change costs one cycle without a word.
module prbs_word_gen
    import prbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [1:0]        sel_i,
    input  logic              inv_i,
    output logic [WORD_W-1:0] data_o,
    output logic              valid_o
);

    logic [REG_W-1:0]  st_q;
    logic [REG_W-1:0]  nxt_st [NUM_PAT];
    logic [WORD_W-1:0] nxt_wd [NUM_PAT];
    logic [1:0]        mode;
    logic              adv;
    logic              seed;

    prbs_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .sel_i  (sel_i),
        .mode_o (mode),
        .adv_o  (adv),
        .seed_o (seed)
    );

    // One stepper per polynomial, sized from the package tables.
    for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
        localparam int LEN = pat_len(g);
        localparam int TP  = pat_tap(g);
        logic [LEN-1:0] ns;

        prbs_leap #(.N(LEN), .TAP(TP), .W(WORD_W)) u_leap (
            .state_i (st_q[LEN-1:0]),
            .state_o (ns),
            .word_o  (nxt_wd[g])
        );

        assign nxt_st[g] = REG_W'(ns);
    end

    // State register: seed on reset or pattern change, step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || seed) st_q <= '1;
        else if (adv)       st_q <= nxt_st[mode];
    end

    prbs_outreg #(.W(WORD_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (adv),
        .inv_i   (inv_i),
        .word_i  (nxt_wd[mode]),
        .data_o  (data_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/prbs_word_gen_chk.sv
// Checker for prbs_word_gen: port-level temporal properties, attached by bind.
module prbs_word_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        en_i,
    input logic [1:0]  sel_i,
    input logic        inv_i,
    input logic [31:0] data_o,
    input logic        valid_o
);

    // R9: an idle edge yields no word.
    p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !valid_o);

    // R9: an idle edge keeps the data word.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(data_o));

    // R9: a valid word needs enable at the edge that produced it.
    p_valid_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(en_i));

    // R10: a change of effective pattern costs one word slot.
    p_reseed_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != $past(sel_i) && !(sel_i[1] && $past(sel_i[1]))) |=> !valid_o);

    // R12: no degenerate words.
    p_no_lockup_r12: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (data_o != 32'h0 && data_o != 32'hFFFF_FFFF));

endmodule

bind prbs_word_gen prbs_word_gen_chk u_chk (.*);

// File: tb/sim_prbs_word_gen.sv
`timescale 1ns/1ps
module sim_prbs_word_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [1:0]  sel_i = 2'b10;
    logic        inv_i = 1'b0;
    logic [31:0] data_o;
    logic        valid_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic [30:0] ms;           // serial reference state
    int          m_len, m_tap;

    always #2 clk = ~clk;

    prbs_word_gen u0 (.*);

    // Serial reference: 32 steps of the documented convention.
    task automatic model_word(output logic [31:0] w);
        logic fb;
        logic [30:0] mask;
        mask = 31'h7FFF_FFFF >> (31 - m_len);
        for (int i = 0; i < 32; i++) begin
            fb   = ms[m_tap-1] ^ ms[m_len-1];
            w[i] = fb;
            ms   = ({ms[29:0], fb}) & mask;
        end
    endtask

    task automatic model_seed(input int len, input int tap);
        m_len = len; m_tap = tap; ms = '1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: inputs set now (negedge), sample at the next negedge.
    task automatic tick();
        @(negedge clk);
    endtask

    // Emit one enabled word and compare with the model.
    task automatic word_step(input string req, input logic inv, output logic [31:0] got);
        logic [31:0] e;
        en_i = 1'b1; inv_i = inv;
        tick();
        model_word(e);
        check({req, " valid"}, 32'(valid_o), 32'd1);
        check(req, data_o, inv ? ~e : e);
        check("R12 degenerate", 32'(data_o == 32'h0 || data_o == 32'hFFFF_FFFF), 32'd0);
        got = data_o;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en_i = 1'b1; sel_i = 2'b10; inv_i = 1'b0;
        tick(); tick();
        check("R1 valid", 32'(valid_o), 32'd0);
        check("R1 data", data_o, 32'h0);
        rst_n = 1'b1; en_i = 1'b0;
        tick();
        model_seed(31, 28);
    endtask

    task automatic t_prbs31();
        logic [31:0] w;
        for (int k = 0; k < 40; k++) word_step("R5 R6 R7 prbs31", 1'b0, w);
    endtask

    task automatic t_prbs7_period();
        logic [31:0] w [127];
        en_i = 1'b1; sel_i = 2'b00;
        tick();
        check("R10 reseed gap", 32'(valid_o), 32'd0);
        model_seed(7, 6);
        for (int k = 0; k < 127; k++) word_step("R3 prbs7", 1'b0, w[k]);
        check("R2 first bits", 32'(w[0][6:0]), 32'h40);
        for (int b = 127; b < 127 * 32; b++) begin
            if (w[b/32][b%32] !== w[(b-127)/32][(b-127)%32]) begin
                check("R3 period", 32'(b), 32'd0);
                break;
            end
        end
        n_chk++;
    endtask

    task automatic t_prbs23();
        logic [31:0] w;
        en_i = 1'b1; sel_i = 2'b01;
        tick();
        check("R10 reseed gap", 32'(valid_o), 32'd0);
        model_seed(23, 18);
        for (int k = 0; k < 30; k++) word_step("R4 prbs23", 1'b0, w);
    endtask

    task automatic t_invert();
        logic [31:0] w;
        for (int k = 0; k < 12; k++) word_step("R8 invert", k[0], w);
        word_step("R8 default plain", 1'b0, w);
    endtask

    task automatic t_idle();
        logic [31:0] w, last;
        word_step("R9 pre", 1'b0, last);
        en_i = 1'b0; inv_i = 1'b1;
        tick(); tick(); tick();
        check("R9 no valid", 32'(valid_o), 32'd0);
        check("R9 data held", data_o, last);
        for (int k = 0; k < 4; k++) word_step("R9 resume", 1'b0, w);
    endtask

    task automatic t_alias();
        logic [31:0] w;
        en_i = 1'b1; sel_i = 2'b10;
        tick();
        check("R10 reseed gap", 32'(valid_o), 32'd0);
        model_seed(31, 28);
        for (int k = 0; k < 5; k++) word_step("R11 pre", 1'b0, w);
        sel_i = 2'b11;
        for (int k = 0; k < 5; k++) word_step("R11 no reseed", 1'b0, w);
        sel_i = 2'b00;
        tick();
        sel_i = 2'b11;
        tick();
        check("R11 reseed gap", 32'(valid_o), 32'd0);
        model_seed(31, 28);
        for (int k = 0; k < 5; k++) word_step("R11 alias prbs31", 1'b0, w);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        tick();
        t_reset();
        t_prbs31();
        t_prbs7_period();
        t_prbs23();
        t_invert();
        t_idle();
        t_alias();
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule